// File: doc/BRIEF.md
# Bridge Driver Protection Supervisor

This block gathers the protection conditions of a multi-bridge motor driver and decides whether the power outputs may conduct. It receives one short-circuit flag per bridge, a digitised supply-voltage code, a flag reporting a weak charge-pump rail, a digitised die-temperature code and an active-low sleep request. From these it produces a global output enable, an enable for the charge pump, and an active-low fault indication that models an open-drain pin.

Two kinds of fault are kept apart. A short circuit is latched, and only a sleep request or a power-on reset clears it. Over-temperature, supply undervoltage and a weak charge pump clear themselves once the condition has gone. The temperature and supply comparisons each use two thresholds, so a code that wanders near one threshold does not toggle the enable. Only the latched short circuit pulls the fault indication low.

All inputs are sampled on the rising clock edge. Every output reflects the inputs sampled at the previous edge, so each output lags its inputs by exactly one cycle. The pins are plain control and status signals. No stream interface, and so no back-pressure, is involved.

Top module: `drv_fault_sup`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_en is 0, cp_en is 0 and fault_n is 1. The undervoltage lockout starts active.
- R2: Undervoltage releases in the cycle after vsup_code is at least UV_RISE (default 38). It trips in the cycle after vsup_code is below UV_FALL (default 36). For codes in between, the previous state is kept.
- R3: Over-temperature trips in the cycle after temp_code is at least OT_SET (default 165). It releases in the cycle after temp_code is below OT_CLR (default 150). For codes in between, the previous state is kept.
- R4: cp_low high disables out_en in the next cycle. The output enable returns on its own in the cycle after cp_low falls, provided no other fault is present.
- R5: A high level on any bit of ocp_flag while sleep_n is high latches a short-circuit fault. From the next cycle, out_en is 0 and fault_n is 0. Both stay that way after the flag drops.
- R6: The short-circuit latch ignores changes in temperature, supply and charge-pump condition. It clears only through reset, or in the cycle after sleep_n is sampled low.
- R7: sleep_n low forces out_en and cp_en to 0 in the next cycle. While sleep_n is low, ocp_flag has no effect.
- R8: fault_n is low only while the short-circuit latch is set. Thermal, undervoltage and charge-pump faults leave it high.
- R9: out_en is 1 exactly when, at the previous edge, the short-circuit latch was clear, temperature and supply were in their good states, cp_low was 0 and sleep_n was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ocp_flag | input | N_BRIDGE | Per-bridge short-circuit detect flags |
| vsup_code | input | SUP_W | Digitised supply voltage |
| cp_low | input | 1 | Charge-pump rail below its minimum |
| temp_code | input | TEMP_W | Digitised junction temperature |
| sleep_n | input | 1 | Active-low sleep request |
| out_en | output | 1 | Global enable for all bridge outputs |
| cp_en | output | 1 | Charge-pump enable |
| fault_n | output | 1 | Active-low latched short-circuit indication |

## Verification
The bench sweeps the supply and temperature codes over their whole range, first upward and then downward. This exposes a comparator that swaps its thresholds, uses the wrong bound, or loses its hysteresis: such a design would toggle out_en inside the band or trip one code off. Every bridge flag is fired on its own. A latch wired to only some bridges would leave out_en high. The bench also tries to clear the latch with self-clearing faults and their recovery, which a latch that forgot its state would allow. It fires a flag during sleep, where a design that failed to mask it would pull fault_n low. Finally, all sixteen combinations of the self-clearing conditions and sleep are applied, which catches a wrong term in the enable product.

// File: rtl/drv_fault_pkg.sv
package drv_fault_pkg;
  // Active-high fault state held by the supervisor
  typedef struct packed {
    logic short_lat;
    logic hot;
    logic undervolt;
    logic pump_weak;
  } fault_state_t;
endpackage

// File: rtl/drv_hyst_cmp.sv
// Two-threshold comparator with a registered state.
// TRIP_HIGH=1: trips at code >= TRIP_LVL, releases at code < REL_LVL.
// TRIP_HIGH=0: trips at code < TRIP_LVL, releases at code >= REL_LVL.
module drv_hyst_cmp #(
  parameter int W         = 8,
  parameter int TRIP_LVL  = 165,
  parameter int REL_LVL   = 150,
  parameter bit TRIP_HIGH = 1'b1,
  parameter bit RST_VAL   = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] code,
  output logic         tripped
);
  localparam logic [W-1:0] TripC = W'(TRIP_LVL);
  localparam logic [W-1:0] RelC  = W'(REL_LVL);

  logic do_trip, do_rel;

  generate
    if (TRIP_HIGH) begin : g_high
      assign do_trip = (code >= TripC);
      assign do_rel  = (code <  RelC);
    end else begin : g_low
      assign do_trip = (code <  TripC);
      assign do_rel  = (code >= RelC);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tripped <= RST_VAL;
    else if (do_trip) tripped <= 1'b1;
    else if (do_rel)  tripped <= 1'b0;
  end
endmodule

// File: rtl/drv_short_latch.sv
// Sticky short-circuit fault; sleep request clears it and masks new flags.
module drv_short_latch #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flag,
  input  logic         awake,
  output logic         latched
);
  logic any_flag;
  assign any_flag = |flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latched <= 1'b0;
    else if (!awake)   latched <= 1'b0;
    else if (any_flag) latched <= 1'b1;
  end
endmodule

// File: rtl/drv_fault_sup.sv
module drv_fault_sup #(
  parameter int N_BRIDGE = 4,
  parameter int SUP_W    = 6,
  parameter int TEMP_W   = 8,
  parameter int UV_RISE  = 38,
  parameter int UV_FALL  = 36,
  parameter int OT_SET   = 165,
  parameter int OT_CLR   = 150
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_BRIDGE-1:0] ocp_flag,
  input  logic [SUP_W-1:0]    vsup_code,
  input  logic                cp_low,
  input  logic [TEMP_W-1:0]   temp_code,
  input  logic                sleep_n,
  output logic                out_en,
  output logic                cp_en,
  output logic                fault_n
);
  import drv_fault_pkg::*;

  fault_state_t st;
  logic         awake_q;

  drv_short_latch #(.N(N_BRIDGE)) u_short (
    .clk(clk), .rst_n(rst_n), .flag(ocp_flag), .awake(sleep_n),
    .latched(st.short_lat)
  );

  drv_hyst_cmp #(
    .W(TEMP_W), .TRIP_LVL(OT_SET), .REL_LVL(OT_CLR),
    .TRIP_HIGH(1'b1), .RST_VAL(1'b0)
  ) u_therm (
    .clk(clk), .rst_n(rst_n), .code(temp_code), .tripped(st.hot)
  );

  drv_hyst_cmp #(
    .W(SUP_W), .TRIP_LVL(UV_FALL), .REL_LVL(UV_RISE),
    .TRIP_HIGH(1'b0), .RST_VAL(1'b1)
  ) u_uvlo (
    .clk(clk), .rst_n(rst_n), .code(vsup_code), .tripped(st.undervolt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st.pump_weak <= 1'b0;
      awake_q      <= 1'b0;
    end else begin
      st.pump_weak <= cp_low;
      awake_q      <= sleep_n;
    end
  end

  assign out_en  = awake_q && (st == '0);
  assign cp_en   = awake_q;
  assign fault_n = ~st.short_lat;
endmodule

// File: rtl/drv_fault_sup_chk.sv
module drv_fault_sup_chk #(
  parameter int N_BRIDGE = 4,
  parameter int SUP_W    = 6,
  parameter int TEMP_W   = 8,
  parameter int UV_FALL  = 36,
  parameter int OT_SET   = 165
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_BRIDGE-1:0] ocp_flag,
  input logic [SUP_W-1:0]    vsup_code,
  input logic                cp_low,
  input logic [TEMP_W-1:0]   temp_code,
  input logic                sleep_n,
  input logic                out_en,
  input logic                cp_en,
  input logic                fault_n
);
  // R1
  always_comb if (!rst_n) rst_state_chk: assert (!out_en && !cp_en && fault_n);

  // R2
  uv_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vsup_code < SUP_W'(UV_FALL)) |=> !out_en);

  // R3
  ot_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_code >= TEMP_W'(OT_SET)) |=> !out_en);

  // R4
  cp_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cp_low |=> !out_en);

  // R5
  short_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_n && (|ocp_flag)) |=> (!fault_n && !out_en));

  // R6
  short_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_n && sleep_n) |=> !fault_n);

  // R7
  sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |=> (!out_en && !cp_en && fault_n));

  // R8
  fault_only_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_n && (ocp_flag == '0)) |=> fault_n);

  // R9
  en_needs_pump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> cp_en);
endmodule

bind drv_fault_sup drv_fault_sup_chk #(
  .N_BRIDGE(N_BRIDGE), .SUP_W(SUP_W), .TEMP_W(TEMP_W),
  .UV_FALL(UV_FALL), .OT_SET(OT_SET)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ocp_flag(ocp_flag), .vsup_code(vsup_code),
  .cp_low(cp_low), .temp_code(temp_code), .sleep_n(sleep_n),
  .out_en(out_en), .cp_en(cp_en), .fault_n(fault_n)
);

// File: tb/drv_fault_sup_tb_top.sv
module drv_fault_sup_tb_top;
  localparam int NB = 4, SW = 6, TW = 8;
  localparam int URISE = 38, UFALL = 36, OSET = 165, OCLR = 150;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NB-1:0] ocp_flag = '0;
  logic [SW-1:0] vsup_code = '0;
  logic cp_low = 1'b0;
  logic [TW-1:0] temp_code = 8'd25;
  logic sleep_n = 1'b0;
  logic out_en, cp_en, fault_n;

  int n_chk = 0, n_fail = 0;
  // bench model of the requirements
  bit m_uv = 1, m_ot = 0, m_cp = 0, m_sl = 0, m_sc = 0;

  always #2 clk = ~clk;

  drv_fault_sup #(
    .N_BRIDGE(NB), .SUP_W(SW), .TEMP_W(TW),
    .UV_RISE(URISE), .UV_FALL(UFALL), .OT_SET(OSET), .OT_CLR(OCLR)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .ocp_flag(ocp_flag), .vsup_code(vsup_code),
    .cp_low(cp_low), .temp_code(temp_code), .sleep_n(sleep_n),
    .out_en(out_en), .cp_en(cp_en), .fault_n(fault_n)
  );

  task automatic chk(input string req);
    bit e_en, e_cp, e_f;
    e_en = m_sl && !m_sc && !m_ot && !m_uv && !m_cp;
    e_cp = m_sl;
    e_f  = !m_sc;
    n_chk++;
    if ({out_en, cp_en, fault_n} !== {e_en, e_cp, e_f}) begin
      n_fail++;
      $display("FAIL %s: out_en/cp_en/fault_n actual %b%b%b expected %b%b%b",
               req, out_en, cp_en, fault_n, e_en, e_cp, e_f);
    end
  endtask

  // one clock: model samples inputs at the edge, outputs checked at negedge
  task automatic tick(input string req);
    @(posedge clk);
    if (int'(vsup_code) >= URISE) m_uv = 0;
    else if (int'(vsup_code) < UFALL) m_uv = 1;
    if (int'(temp_code) >= OSET) m_ot = 1;
    else if (int'(temp_code) < OCLR) m_ot = 0;
    m_cp = cp_low;
    m_sc = sleep_n ? (m_sc | (|ocp_flag)) : 1'b0;
    m_sl = sleep_n;
    @(negedge clk);
    chk(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset");
    rst_n = 1'b1;
    sleep_n = 1'b1;
    tick("R1 first cycle");           // uv still set (code 0)

    // R2 supply sweep up then down
    for (int v = 0; v < 64; v++) begin
      vsup_code = SW'(v);
      tick("R2 supply rising");
    end
    for (int v = 63; v >= 0; v--) begin
      vsup_code = SW'(v);
      tick("R2 supply falling");
    end
    vsup_code = 6'd50;
    tick("R2 recover");

    // R3 temperature sweep up then down
    for (int t = 0; t < 256; t++) begin
      temp_code = TW'(t);
      tick("R3 temp rising");
    end
    for (int t = 255; t >= 0; t--) begin
      temp_code = TW'(t);
      tick("R3 temp falling");
    end
    temp_code = 8'd25;

    // R4 charge pump
    cp_low = 1'b1; tick("R4 pump weak");
    cp_low = 1'b0; tick("R4 pump recovered");

    // R5/R6/R7 each bridge separately
    for (int b = 0; b < NB; b++) begin
      ocp_flag = NB'(1) << b; tick("R5 short latch");
      ocp_flag = '0;          tick("R5 short holds");
      temp_code = 8'd200;     tick("R6 hot while latched");
      temp_code = 8'd25;      tick("R6 cool while latched");
      vsup_code = 6'd10;      tick("R6 uv while latched");
      vsup_code = 6'd50;      tick("R8 uv recover latched");
      cp_low = 1'b1;          tick("R6 pump while latched");
      cp_low = 1'b0;          tick("R6 still latched");
      sleep_n = 1'b0;         tick("R7 sleep clears");
      ocp_flag = '1;          tick("R7 flag ignored in sleep");
      ocp_flag = '0; sleep_n = 1'b1; tick("R7 wake clean");
    end

    // R8/R9 all combinations of self-clearing conditions and sleep
    for (int c = 0; c < 16; c++) begin
      vsup_code = c[0] ? 6'd20 : 6'd50;
      temp_code = c[1] ? 8'd180 : 8'd25;
      cp_low    = c[2];
      sleep_n   = !c[3];
      tick("R9 enable product");
      tick("R8 no fault pin");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule